// File: doc/BRIEF.md
# Handshaked Byte-Serial Command Engine

This block is the device-side protocol engine for a byte-serial command channel. A host moves bytes through a shift register and paces every byte with two active-low lines held in a shared parallel port register: a request line the host drives and an acknowledge line the engine drives. The engine takes a command code, an optional length byte and argument bytes into a buffer. It hands the finished command to an external dispatcher and then returns a response, which may start with a size byte.

Each command code selects a command length and a response length from a computed table. Either length may be fixed or variable. A variable command length arrives as the first byte after the code. A variable response length goes out as the first response byte. Codes the table does not mark as known are never dispatched; the engine answers them with zeros. While a transaction is open, the engine holds a signal that blocks background bus polling. After every accepted byte it pulses a one-cycle shift-complete strobe.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset the port register reads 0x18 (acknowledge bit 3 and request bit 4 high, all other bits zero), the engine is idle, `poll_block` is low and neither `sr_done` nor `disp_start` pulses.
- R2: When the port value differs from the engine's last sampled copy and shows request (bit 4) high with acknowledge (bit 3) low, the engine drives acknowledge high and processes no byte.
- R3: A port value with both handshake bits high, or both low, is left as written and causes no byte processing, no `sr_done` pulse and no state change.
- R4: A port value with request low and acknowledge high is a byte request. Two clock edges after the host write, acknowledge reads low and, when the direction is right, `sr_done` is high for exactly one cycle.
- R5: In the idle and command phases the shift direction must be host-to-device (`sr_host_to_dev` = 1). In the response phase it must be device-to-host. On a mismatch acknowledge is still driven low, but there is no `sr_done` pulse and the byte is not consumed.
- R6: Codes 0x10 (variable/variable), 0x20 (2 arguments/1 response byte), 0x30 (0/variable) and 0x40 (4/0) are known. For every other code, the command length is variable when bit 7 is set and otherwise equals bits 1:0. The response length is variable when bit 6 is set and otherwise equals bits 3:2.
- R7: With a variable command length, the first byte after the code sets the argument count. Argument bytes are stored only while the buffer has room.
- R8: When the stored argument count reaches the command length (already at the code byte when that length is zero), a known command produces a one-cycle `disp_start` pulse carrying the code and the count. Byte requests wait until `disp_done`.
- R9: A fixed response sends exactly the table length in bytes. Byte i is the dispatcher's byte i when i is below the reported size, and 0 otherwise. A fixed length of zero returns the engine to idle at `disp_done`.
- R10: A variable response first sends the reported size as a byte, then that many bytes. A size of zero ends the transaction after the size byte.
- R11: An unknown code is never dispatched. Its response is table-length zero bytes, or a single size byte of 0 when the response length is variable.
- R12: `poll_block` rises when the code byte is accepted and falls when the final response byte has been sent, or at the end of the command when no response bytes are due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the port register |
| host_wdata | input | 8 | Value the host writes to the port register |
| port_q | output | 8 | Current port register, including the acknowledge bit the engine drives |
| sr_host_byte | input | 8 | Byte the host has shifted in |
| sr_host_to_dev | input | 1 | Shift direction, 1 = host to device |
| sr_dev_byte | output | 8 | Byte presented for the host to shift out |
| sr_done | output | 1 | One-cycle shift-complete pulse |
| poll_block | output | 1 | High while a transaction is open |
| disp_start | output | 1 | One-cycle dispatch request |
| disp_cmd | output | 8 | Command code for the dispatcher |
| disp_argc | output | 8 | Stored argument count |
| arg_rd_idx | input | 5 | Argument buffer read index |
| arg_rd_data | output | 8 | Argument byte at `arg_rd_idx` |
| rsp_wr | input | 1 | Response buffer write strobe |
| rsp_wr_idx | input | 5 | Response buffer write index |
| rsp_wr_data | input | 8 | Response byte to write |
| disp_done | input | 1 | Dispatcher completion pulse |
| disp_rsp_len | input | 8 | Response size reported with `disp_done` |

## Verification
The engine acts one edge after the port register takes a host write. Acknowledge, `sr_done` and the outgoing byte are therefore due at the second edge after the write strobe. The bench checks the exact cycle once, then samples on falling edges and polls acknowledge for the remaining handshake steps. `disp_start` is seen on the falling edge after the completing byte, and the bench's dispatcher answers several cycles later. Any request made in the meantime is held, so the bench waits on the acknowledge level rather than a fixed delay. Every non-table code is swept, with the expected lengths and all-zero responses derived from the code bits.

// File: rtl/hs_cmd_pkg.sv
package hs_cmd_pkg;

   typedef enum logic [1:0] {HS_IDLE, HS_RELEASE, HS_REQUEST, HS_INVALID} hs_e;

   typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DISP, ST_RSP} st_e;

   typedef struct packed {
      logic       known;
      logic       cvar;
      logic [7:0] clen;
      logic       rvar;
      logic [7:0] rlen;
   } len_entry_t;

   // Length pair for a command code; codes outside the known set derive
   // their lengths from their own bits.
   function automatic len_entry_t len_lookup(input logic [7:0] c);
      len_entry_t e;
      e.known = 1'b1;
      e.cvar  = 1'b0;
      e.clen  = 8'd0;
      e.rvar  = 1'b0;
      e.rlen  = 8'd0;
      case (c)
         8'h10: begin e.cvar = 1'b1; e.rvar = 1'b1; end
         8'h20: begin e.clen = 8'd2; e.rlen = 8'd1; end
         8'h30: begin e.rvar = 1'b1; end
         8'h40: begin e.clen = 8'd4; end
         default: begin
            e.known = 1'b0;
            e.cvar  = c[7];
            e.clen  = {6'd0, c[1:0]};
            e.rvar  = c[6];
            e.rlen  = {6'd0, c[3:2]};
         end
      endcase
      return e;
   endfunction

endpackage

// File: rtl/hs_cmd_hs_decode.sv
module hs_cmd_hs_decode
   import hs_cmd_pkg::*;
#(
   parameter int PORT_W  = 8,
   parameter int ACK_BIT = 3,
   parameter int REQ_BIT = 4
) (
   input  logic [PORT_W-1:0] port,
   output hs_e               hs
);
   always_comb begin
      case ({port[REQ_BIT], port[ACK_BIT]})
         2'b11:   hs = HS_IDLE;
         2'b10:   hs = HS_RELEASE;
         2'b01:   hs = HS_REQUEST;
         default: hs = HS_INVALID;
      endcase
   end
endmodule

// File: rtl/hs_cmd_len_rom.sv
module hs_cmd_len_rom
   import hs_cmd_pkg::*;
(
   input  logic [7:0] code,
   output len_entry_t ent
);
   always_comb ent = len_lookup(code);
endmodule

// File: rtl/hs_cmd_byte_buf.sv
module hs_cmd_byte_buf #(
   parameter int DEPTH = 32,
   parameter int W     = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);
   logic [W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem[i] <= '0;
         else if (we && widx == IDX_W'(i))      mem[i] <= wdata;
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine
   import hs_cmd_pkg::*;
#(
   parameter int PORT_W    = 8,
   parameter int ACK_BIT   = 3,
   parameter int REQ_BIT   = 4,
   parameter int BUF_DEPTH = 32,
   localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [PORT_W-1:0] host_wdata,
   output logic [PORT_W-1:0] port_q,
   input  logic [7:0]        sr_host_byte,
   input  logic              sr_host_to_dev,
   output logic [7:0]        sr_dev_byte,
   output logic              sr_done,
   output logic              poll_block,
   output logic              disp_start,
   output logic [7:0]        disp_cmd,
   output logic [7:0]        disp_argc,
   input  logic [IDX_W-1:0]  arg_rd_idx,
   output logic [7:0]        arg_rd_data,
   input  logic              rsp_wr,
   input  logic [IDX_W-1:0]  rsp_wr_idx,
   input  logic [7:0]        rsp_wr_data,
   input  logic              disp_done,
   input  logic [7:0]        disp_rsp_len
);
   localparam logic [PORT_W-1:0] PORT_RST =
      (PORT_W'(1) << ACK_BIT) | (PORT_W'(1) << REQ_BIT);
   localparam logic [7:0] DEPTH8 = 8'(BUF_DEPTH);

   if (ACK_BIT == REQ_BIT || ACK_BIT >= PORT_W || REQ_BIT >= PORT_W) begin : g_bad_bits
      $error("handshake bit positions must differ and lie inside the port");
   end
   if (BUF_DEPTH < 2 || BUF_DEPTH > 128 || (1 << IDX_W) != BUF_DEPTH) begin : g_bad_depth
      $error("buffer depth must be a power of two between 2 and 128");
   end

   // state
   logic [PORT_W-1:0] port_b, last_b, port_n, last_n;
   st_e               st, st_n;
   logic [7:0]        code, code_n;
   len_entry_t        cur, cur_n;
   logic [7:0]        apos, apos_n, rpos, rpos_n, rsz, rsz_n;
   logic [7:0]        sr_dev_q, sr_dev_n;
   logic              done_q, done_n, start_q, start_n, block_q, block_n;

   // sub-block links
   hs_e        hs;
   len_entry_t rom_ent;
   logic       arg_we;
   logic [7:0] rsp_rd, rsp_byte;
   logic       cmd_fin, rsp_fin, enter_rsp;

   hs_cmd_hs_decode #(.PORT_W(PORT_W), .ACK_BIT(ACK_BIT), .REQ_BIT(REQ_BIT)) u_dec (
      .port(port_b), .hs(hs));

   hs_cmd_len_rom u_rom (.code(sr_host_byte), .ent(rom_ent));

   hs_cmd_byte_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_args (
      .clk(clk), .rst_n(rst_n), .we(arg_we), .widx(apos[IDX_W-1:0]),
      .wdata(sr_host_byte), .ridx(arg_rd_idx), .rdata(arg_rd_data));

   hs_cmd_byte_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_rsp (
      .clk(clk), .rst_n(rst_n), .we(rsp_wr), .widx(rsp_wr_idx),
      .wdata(rsp_wr_data), .ridx(rpos[IDX_W-1:0]), .rdata(rsp_rd));

   // bytes past the reported size, or of an unknown code, go out as zero
   assign rsp_byte = (cur.known && rpos < rsz && rpos < DEPTH8) ? rsp_rd : 8'h00;

   always_comb begin
      port_n    = port_b;
      last_n    = last_b;
      st_n      = st;
      code_n    = code;
      cur_n     = cur;
      apos_n    = apos;
      rpos_n    = rpos;
      rsz_n     = rsz;
      sr_dev_n  = sr_dev_q;
      done_n    = 1'b0;
      start_n   = 1'b0;
      block_n   = block_q;
      arg_we    = 1'b0;
      cmd_fin   = 1'b0;
      rsp_fin   = 1'b0;
      enter_rsp = 1'b0;

      if (st == ST_DISP && disp_done) begin
         rsz_n     = disp_rsp_len;
         enter_rsp = 1'b1;
      end

      if (host_wr) begin
         port_n = host_wdata;
      end else if (port_b != last_b) begin
         case (hs)
            HS_RELEASE: begin
               port_n[ACK_BIT] = 1'b1;
               last_n          = port_n;
            end
            HS_REQUEST: begin
               if (st != ST_DISP) begin
                  port_n[ACK_BIT] = 1'b0;
                  last_n          = port_n;
                  case (st)
                     ST_IDLE: if (sr_host_to_dev) begin
                        code_n  = sr_host_byte;
                        cur_n   = rom_ent;
                        apos_n  = 8'd0;
                        rpos_n  = 8'd0;
                        st_n    = ST_CMD;
                        block_n = 1'b1;
                        done_n  = 1'b1;
                        cmd_fin = !rom_ent.cvar && rom_ent.clen == 8'd0;
                     end
                     ST_CMD: if (sr_host_to_dev) begin
                        done_n = 1'b1;
                        if (cur.cvar) begin
                           cur_n.clen = sr_host_byte;
                           cur_n.cvar = 1'b0;
                           cmd_fin    = sr_host_byte == 8'd0;
                        end else if (apos < DEPTH8) begin
                           arg_we  = 1'b1;
                           apos_n  = apos + 8'd1;
                           cmd_fin = (apos + 8'd1) == cur.clen;
                        end
                     end
                     ST_RSP: if (!sr_host_to_dev) begin
                        done_n = 1'b1;
                        if (cur.rvar) begin
                           sr_dev_n   = rsz;
                           cur_n.rlen = rsz;
                           cur_n.rvar = 1'b0;
                           rsp_fin    = rsz == 8'd0;
                        end else begin
                           sr_dev_n = rsp_byte;
                           rpos_n   = rpos + 8'd1;
                           rsp_fin  = (rpos + 8'd1) == cur.rlen;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            default: last_n = port_b;
         endcase
      end

      if (cmd_fin) begin
         if (cur_n.known) begin
            st_n    = ST_DISP;
            start_n = 1'b1;
         end else begin
            rsz_n     = cur_n.rvar ? 8'd0 : cur_n.rlen;
            enter_rsp = 1'b1;
         end
      end
      if (enter_rsp) begin
         st_n = ST_RSP;
         if (!cur_n.rvar && cur_n.rlen == 8'd0) rsp_fin = 1'b1;
      end
      if (rsp_fin) begin
         st_n    = ST_IDLE;
         block_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_b   <= PORT_RST;
         last_b   <= PORT_RST;
         st       <= ST_IDLE;
         code     <= 8'd0;
         cur      <= '0;
         apos     <= 8'd0;
         rpos     <= 8'd0;
         rsz      <= 8'd0;
         sr_dev_q <= 8'd0;
         done_q   <= 1'b0;
         start_q  <= 1'b0;
         block_q  <= 1'b0;
      end else begin
         port_b   <= port_n;
         last_b   <= last_n;
         st       <= st_n;
         code     <= code_n;
         cur      <= cur_n;
         apos     <= apos_n;
         rpos     <= rpos_n;
         rsz      <= rsz_n;
         sr_dev_q <= sr_dev_n;
         done_q   <= done_n;
         start_q  <= start_n;
         block_q  <= block_n;
      end
   end

   assign port_q      = port_b;
   assign sr_dev_byte = sr_dev_q;
   assign sr_done     = done_q;
   assign disp_start  = start_q;
   assign disp_cmd    = code;
   assign disp_argc   = apos;
   assign poll_block  = block_q;
endmodule

// File: rtl/hs_cmd_engine_chk.sv
module hs_cmd_engine_chk #(
   parameter int PORT_W    = 8,
   parameter int ACK_BIT   = 3,
   parameter int REQ_BIT   = 4,
   parameter int BUF_DEPTH = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [PORT_W-1:0] port_q,
   input logic              sr_done,
   input logic              poll_block,
   input logic              disp_start,
   input logic [7:0]        disp_argc
);
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (port_q[ACK_BIT] && port_q[REQ_BIT] && !poll_block && !sr_done));

   a_r2_release_raises_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_wr) && !host_wr && port_q[REQ_BIT] && !port_q[ACK_BIT]) |=> port_q[ACK_BIT]);

   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      sr_done |=> !sr_done);

   a_r4_done_with_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      sr_done |-> !port_q[ACK_BIT]);

   a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      disp_start |=> !disp_start);

   a_r8_argc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      disp_start |-> (disp_argc <= 8'(BUF_DEPTH)));

   a_r12_block_in_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      disp_start |-> poll_block);
endmodule

bind hs_cmd_engine hs_cmd_engine_chk #(
   .PORT_W(PORT_W), .ACK_BIT(ACK_BIT), .REQ_BIT(REQ_BIT), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .port_q(port_q),
   .sr_done(sr_done), .poll_block(poll_block), .disp_start(disp_start),
   .disp_argc(disp_argc)
);

// File: tb/hs_cmd_engine_test.sv
`timescale 1ns/1ps
module hs_cmd_engine_test;
   logic       clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
   logic [7:0] host_wdata = 8'h00, sr_host_byte = 8'h00;
   logic       sr_host_to_dev = 1'b1;
   logic [4:0] arg_rd_idx = 5'd0, rsp_wr_idx = 5'd0;
   logic       rsp_wr = 1'b0, disp_done = 1'b0;
   logic [7:0] rsp_wr_data = 8'h00, disp_rsp_len = 8'h00;
   logic [7:0] port_q, sr_dev_byte, disp_cmd, disp_argc, arg_rd_data;
   logic       sr_done, poll_block, disp_start;

   int checks = 0, errors = 0, done_cnt = 0, disp_cnt = 0;
   logic [7:0] last_out = 8'h00, d_cmd = 8'h00, d_argc = 8'h00;
   logic [7:0] d_args [32];
   logic [7:0] b;

   hs_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .port_q(port_q), .sr_host_byte(sr_host_byte), .sr_host_to_dev(sr_host_to_dev),
      .sr_dev_byte(sr_dev_byte), .sr_done(sr_done), .poll_block(poll_block),
      .disp_start(disp_start), .disp_cmd(disp_cmd), .disp_argc(disp_argc),
      .arg_rd_idx(arg_rd_idx), .arg_rd_data(arg_rd_data), .rsp_wr(rsp_wr),
      .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data), .disp_done(disp_done),
      .disp_rsp_len(disp_rsp_len));

   always #2 clk = ~clk;

   always @(negedge clk) if (sr_done) begin
      done_cnt++;
      last_out = sr_dev_byte;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic wr_port(input logic [7:0] v);
      @(negedge clk); host_wr = 1'b1; host_wdata = v;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic xfer(input logic h2d, input logic [7:0] v);
      sr_host_byte = v; sr_host_to_dev = h2d;
      wr_port(8'h08);
      while (port_q[3]) @(negedge clk);
      wr_port(8'h10);
      while (port_q != 8'h18) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] v);
      xfer(1'b1, v);
   endtask

   task automatic recv(output logic [7:0] v);
      xfer(1'b0, 8'h00);
      v = last_out;
   endtask

   task automatic wait_disp(input int n);
      while (disp_cnt < n) @(negedge clk);
   endtask

   // dispatcher model
   initial begin
      logic [7:0] rsp [32];
      int len;
      forever begin
         @(negedge clk);
         if (disp_start) begin
            d_cmd = disp_cmd; d_argc = disp_argc;
            for (int i = 0; i < int'(d_argc) && i < 32; i++) begin
               arg_rd_idx = 5'(i);
               @(negedge clk);
               d_args[i] = arg_rd_data;
            end
            len = 0;
            case (d_cmd)
               8'h10: begin len = int'(d_argc);
                  for (int i = 0; i < len; i++) rsp[i] = d_args[i] ^ 8'hA5; end
               8'h20: begin len = 1; rsp[0] = d_args[0] + d_args[1]; end
               8'h30: begin len = 3;
                  for (int i = 0; i < 3; i++) rsp[i] = 8'h30 + 8'(i); end
               default: len = 0;
            endcase
            for (int i = 0; i < len; i++) begin
               rsp_wr = 1'b1; rsp_wr_idx = 5'(i); rsp_wr_data = rsp[i];
               @(negedge clk);
            end
            rsp_wr = 1'b0;
            repeat (2) @(negedge clk);
            disp_done = 1'b1; disp_rsp_len = 8'(len);
            disp_cnt++;
            @(negedge clk);
            disp_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int dc, dd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 port", port_q, 8'h18);
      chk("R1 poll_block", poll_block, 0);
      chk("R1 sr_done", sr_done, 0);
      chk("R1 disp_start", disp_start, 0);

      // R3: both low, then both high
      wr_port(8'h00); repeat (3) @(negedge clk);
      chk("R3 invalid left as written", port_q, 8'h00);
      chk("R3 invalid no byte", done_cnt, 0);
      wr_port(8'h18); repeat (3) @(negedge clk);
      chk("R3 idle value", port_q, 8'h18);
      chk("R3 idle no block", poll_block, 0);

      // R4 exact timing with code 0x20 (R6: 2 args, 1 response byte)
      sr_host_byte = 8'h20; sr_host_to_dev = 1'b1;
      @(negedge clk); host_wr = 1'b1; host_wdata = 8'h08;
      @(negedge clk); host_wr = 1'b0;
      @(negedge clk);
      chk("R4 ack low", port_q, 8'h00);
      chk("R4 sr_done", sr_done, 1);
      chk("R12 block raised", poll_block, 1);
      wr_port(8'h10); @(negedge clk);
      chk("R2 ack released", port_q, 8'h18);
      chk("R4 single pulse", done_cnt, 1);
      send(8'h11);
      chk("R12 still blocked", poll_block, 1);
      send(8'h22);
      wait_disp(1);
      chk("R8 cmd", d_cmd, 8'h20);
      chk("R8 argc", d_argc, 2);
      chk("R8 arg0", d_args[0], 8'h11);
      chk("R8 arg1", d_args[1], 8'h22);
      recv(b);
      chk("R9 fixed byte", b, 8'h33);
      repeat (2) @(negedge clk);
      chk("R12 released", poll_block, 0);

      // R7 / R10 variable both ways
      send(8'h10); send(8'h03); send(8'hA0); send(8'hB1); send(8'hC2);
      wait_disp(2);
      chk("R7 argc", d_argc, 3);
      chk("R7 arg2", d_args[2], 8'hC2);
      recv(b); chk("R10 size byte", b, 3);
      recv(b); chk("R10 byte0", b, 8'hA0 ^ 8'hA5);
      recv(b); chk("R10 byte1", b, 8'hB1 ^ 8'hA5);
      recv(b); chk("R10 byte2", b, 8'hC2 ^ 8'hA5);
      repeat (2) @(negedge clk);
      chk("R12 after variable", poll_block, 0);

      // R8 zero-length command dispatches on the code byte
      send(8'h30);
      wait_disp(3);
      chk("R8 zero argc", d_argc, 0);
      recv(b); chk("R10 size 3", b, 3);
      for (int i = 0; i < 3; i++) begin
         recv(b); chk("R10 seq byte", b, 8'h30 + i);
      end

      // R9 zero-length fixed response
      send(8'h40); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
      wait_disp(4);
      chk("R8 argc four", d_argc, 4);
      dd = done_cnt;
      repeat (6) @(negedge clk);
      chk("R9 idle after empty response", poll_block, 0);
      chk("R9 no extra byte", done_cnt, dd);

      // R5 direction mismatch in idle and in response
      dc = done_cnt;
      xfer(1'b0, 8'h55);
      chk("R5 idle mismatch no pulse", done_cnt, dc);
      chk("R5 idle mismatch no block", poll_block, 0);
      send(8'h20); send(8'h01); send(8'h02);
      wait_disp(5);
      dc = done_cnt;
      xfer(1'b1, 8'h77);
      chk("R5 rsp mismatch no pulse", done_cnt, dc);
      recv(b); chk("R5 byte not consumed", b, 8'h03);
      repeat (2) @(negedge clk);
      chk("R5 transaction closed", poll_block, 0);

      // R11 sweep of every code outside the known set (lengths per R6)
      for (int c = 0; c < 256; c++) begin
         logic [7:0] cc;
         int n, rl;
         cc = 8'(c);
         if (cc == 8'h10 || cc == 8'h20 || cc == 8'h30 || cc == 8'h40) continue;
         dc = disp_cnt;
         send(cc);
         if (cc[7]) begin n = int'(cc[5:4]); send(8'(n)); end
         else n = int'(cc[1:0]);
         for (int i = 0; i < n; i++) send(8'hE0 + 8'(i));
         if (cc[6]) begin
            recv(b); chk("R11 variable size zero", b, 0);
         end else begin
            rl = int'(cc[3:2]);
            for (int i = 0; i < rl; i++) begin
               recv(b); chk("R11 zero byte", b, 0);
            end
         end
         repeat (2) @(negedge clk);
         chk("R11 closed", poll_block, 0);
         chk("R11 not dispatched", disp_cnt, dc);
      end

      summary();
      $finish;
   end
endmodule